// File: doc/BRIEF.md
# 8/16-bit Condition Code Flag Unit

This block works out the negative (N), zero (Z), overflow (V) and carry (C) flags that a small CPU core writes after an arithmetic step. The ALU datapath outside the block supplies the two operands, the result it has already produced, the class of the operation and an operand width of 8 or 16 bits. The block has no state. It returns a full condition-code byte in the same cycle.

Carry and overflow come from bitwise equations on the most significant bit of the operands and the result. The block never adds the operands again. The shift class takes its carry from the incoming C flag, which the shifter has already set. Its overflow is that carry XOR the new N. The test class clears V. A per-flag update enable lets the instruction decoder refresh only the flags that an instruction writes. The four remaining bits of the byte (I, H, X, S) pass straight through.

Condition-code byte layout, bit 7 down to bit 0: S, X, H, I, N, Z, V, C. The update enable vector uses the same order for its low four bits: bit 3 is N, bit 2 is Z, bit 1 is V, bit 0 is C. Operation class encoding: 0 is add, 1 is subtract, 2 is shift, 3 is test.

Top module: `cc_flag_unit`

## Requirements
- R1: For add, C is the top bit of (a&b)|(b&~r)|(a&~r).
- R2: For add, V is the top bit of (a&b&~r)|(~a&~b&r).
- R3: For subtract, C is the top bit of (~a&b)|(b&r)|(~a&r).
- R4: For subtract, V is the top bit of (a&~b&~r)|(~a&b&r).
- R5: For shift, N is the result top bit and Z is set when the result is zero. C keeps its input value, and V equals the new N XOR that input C.
- R6: For test, V is 0, N is the result top bit, Z is set when the result is zero, and C keeps its input value.
- R7: For add and subtract, N is the result top bit and Z is set when the result is zero.
- R8: The top bit is bit 7 when wide_i is 0 and bit 15 when wide_i is 1. In 8-bit mode, bits 15..8 of a, b and r have no effect on any flag, Z included.
- R9: A flag whose update enable bit is 0 keeps its input value on ccr_o.
- R10: Bits 7..4 (S, X, H, I) of ccr_o always equal those of ccr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| r_i | input | 16 | Result produced by the datapath |
| op_i | input | 2 | Operation class: 0 add, 1 sub, 2 shift, 3 test |
| wide_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| ccr_i | input | 8 | Current condition-code byte |
| upd_en_i | input | 4 | Update enables for N, Z, V, C (bits 3..0) |
| ccr_o | output | 8 | New condition-code byte |

## Verification
Random operands with random results exercise every combination of the three top bits. This separates the add and subtract equations from each other and from a real adder. Directed cases use true sums and differences at the signed and unsigned limits (0x7F+1, 0xFF+1, 0x8000-1, 0-1) in both widths, so that carry, overflow and zero land where they would in real arithmetic. In 8-bit mode the upper bytes are filled with random noise, which exposes any use of bit 15 or of the upper byte in the zero test. Random update enables with random incoming flag bytes show that disabled flags and the pass-through bits keep their values.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
    parameter int unsigned DATA_W   = 16;
    parameter int unsigned NARROW_W = 8;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_SHIFT = 2'd2,
        CLS_TEST  = 2'd3
    } op_cls_e;

    localparam int unsigned CCR_W    = 8;
    localparam int unsigned ARITH_N  = 4;
    localparam int unsigned BIT_C    = 0;
    localparam int unsigned BIT_V    = 1;
    localparam int unsigned BIT_Z    = 2;
    localparam int unsigned BIT_N    = 3;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;
endpackage

// File: rtl/ccu_width_view.sv
module ccu_width_view #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] r_i,
    input  logic              wide_i,
    output logic              a_top_o,
    output logic              b_top_o,
    output logic              r_top_o,
    output logic              r_zero_o
);
    localparam int unsigned TOP_W = DATA_W - 1;
    localparam int unsigned TOP_N = NARROW_W - 1;

    logic zero_narrow;
    logic zero_wide;

    assign zero_narrow = ~|r_i[TOP_N:0];
    assign zero_wide   = ~|r_i;

    always_comb begin
        if (wide_i) begin
            a_top_o  = a_i[TOP_W];
            b_top_o  = b_i[TOP_W];
            r_top_o  = r_i[TOP_W];
            r_zero_o = zero_wide;
        end else begin
            a_top_o  = a_i[TOP_N];
            b_top_o  = b_i[TOP_N];
            r_top_o  = r_i[TOP_N];
            r_zero_o = zero_narrow;
        end
    end
endmodule

// File: rtl/ccu_carry_ovf.sv
module ccu_carry_ovf (
    input  logic a_top_i,
    input  logic b_top_i,
    input  logic r_top_i,
    input  logic sub_i,
    output logic c_o,
    output logic v_o
);
    logic add_c, add_v, sub_c, sub_v;

    assign add_c = (a_top_i & b_top_i) | (b_top_i & ~r_top_i) | (a_top_i & ~r_top_i);
    assign add_v = (a_top_i & b_top_i & ~r_top_i) | (~a_top_i & ~b_top_i & r_top_i);
    assign sub_c = (~a_top_i & b_top_i) | (b_top_i & r_top_i) | (~a_top_i & r_top_i);
    assign sub_v = (a_top_i & ~b_top_i & ~r_top_i) | (~a_top_i & b_top_i & r_top_i);

    assign c_o = sub_i ? sub_c : add_c;
    assign v_o = sub_i ? sub_v : add_v;
endmodule

// File: rtl/ccu_flag_merge.sv
module ccu_flag_merge
    import ccu_pkg::*;
(
    input  op_cls_e           op_i,
    input  logic              r_top_i,
    input  logic              r_zero_i,
    input  logic              arith_c_i,
    input  logic              arith_v_i,
    input  logic [CCR_W-1:0]  ccr_i,
    input  logic [ARITH_N-1:0] upd_en_i,
    output logic [CCR_W-1:0]  ccr_o
);
    nzvc_t cand;
    logic  c_in;

    assign c_in = ccr_i[BIT_C];

    always_comb begin
        cand.n = r_top_i;
        cand.z = r_zero_i;
        unique case (op_i)
            CLS_ADD, CLS_SUB: begin
                cand.c = arith_c_i;
                cand.v = arith_v_i;
            end
            CLS_SHIFT: begin
                cand.c = c_in;
                cand.v = r_top_i ^ c_in;
            end
            CLS_TEST: begin
                cand.c = c_in;
                cand.v = 1'b0;
            end
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < ARITH_N; gi++) begin : g_flag
            assign ccr_o[gi] = upd_en_i[gi] ? cand[gi] : ccr_i[gi];
        end
        for (gi = ARITH_N; gi < CCR_W; gi++) begin : g_pass
            assign ccr_o[gi] = ccr_i[gi];
        end
    endgenerate
endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
    import ccu_pkg::*;
#(
    parameter int unsigned DW = ccu_pkg::DATA_W,
    parameter int unsigned NW = ccu_pkg::NARROW_W
) (
    input  logic [DW-1:0]      a_i,
    input  logic [DW-1:0]      b_i,
    input  logic [DW-1:0]      r_i,
    input  logic [1:0]         op_i,
    input  logic               wide_i,
    input  logic [CCR_W-1:0]   ccr_i,
    input  logic [ARITH_N-1:0] upd_en_i,
    output logic [CCR_W-1:0]   ccr_o
);
    op_cls_e op_cls;
    logic    a_top, b_top, r_top, r_zero;
    logic    ar_c, ar_v;

    assign op_cls = op_cls_e'(op_i);

    ccu_width_view #(.DATA_W(DW), .NARROW_W(NW)) u_view (
        .a_i     (a_i),
        .b_i     (b_i),
        .r_i     (r_i),
        .wide_i  (wide_i),
        .a_top_o (a_top),
        .b_top_o (b_top),
        .r_top_o (r_top),
        .r_zero_o(r_zero)
    );

    ccu_carry_ovf u_cv (
        .a_top_i(a_top),
        .b_top_i(b_top),
        .r_top_i(r_top),
        .sub_i  (op_cls == CLS_SUB),
        .c_o    (ar_c),
        .v_o    (ar_v)
    );

    ccu_flag_merge u_merge (
        .op_i     (op_cls),
        .r_top_i  (r_top),
        .r_zero_i (r_zero),
        .arith_c_i(ar_c),
        .arith_v_i(ar_v),
        .ccr_i    (ccr_i),
        .upd_en_i (upd_en_i),
        .ccr_o    (ccr_o)
    );
endmodule

// File: rtl/cc_flag_unit_chk.sv
module cc_flag_unit_chk (
    input logic [15:0] a_i,
    input logic [15:0] b_i,
    input logic [15:0] r_i,
    input logic [1:0]  op_i,
    input logic        wide_i,
    input logic [7:0]  ccr_i,
    input logic [3:0]  upd_en_i,
    input logic [7:0]  ccr_o
);
    logic known;
    logic rt;

    assign known = !$isunknown({a_i, b_i, r_i, op_i, wide_i, ccr_i, upd_en_i});
    assign rt    = wide_i ? r_i[15] : r_i[7];

    always_comb begin
        if (known) begin
            AST_UPPER_PASS: assert (ccr_o[7:4] == ccr_i[7:4]); // R10
            AST_HOLD_N: assert (upd_en_i[3] || ccr_o[3] == ccr_i[3]); // R9
            AST_HOLD_C: assert (upd_en_i[0] || ccr_o[0] == ccr_i[0]); // R9
            AST_TEST_CLEARS_V: assert (!(op_i == 2'd3 && upd_en_i[1]) || !ccr_o[1]); // R6
            AST_SHIFT_KEEPS_C: assert (!(op_i == 2'd2) || ccr_o[0] == ccr_i[0]); // R5
            AST_SHIFT_V_RULE: assert (!(op_i == 2'd2 && upd_en_i[1] && upd_en_i[3])
                                      || ccr_o[1] == (ccr_o[3] ^ ccr_o[0])); // R5
            AST_N_IS_TOP: assert (!upd_en_i[3] || ccr_o[3] == rt); // R8
        end
    end
endmodule

bind cc_flag_unit cc_flag_unit_chk u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .r_i     (r_i),
    .op_i    (op_i),
    .wide_i  (wide_i),
    .ccr_i   (ccr_i),
    .upd_en_i(upd_en_i),
    .ccr_o   (ccr_o)
);

// File: tb/sim_cc_flag_unit.sv
module sim_cc_flag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a, b, r;
    logic [1:0]  op;
    logic        wide;
    logic [7:0]  ccr_in;
    logic [3:0]  en;
    logic [7:0]  ccr_out;
    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    cc_flag_unit u0 (
        .a_i(a), .b_i(b), .r_i(r), .op_i(op), .wide_i(wide),
        .ccr_i(ccr_in), .upd_en_i(en), .ccr_o(ccr_out)
    );

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x + y + z) >= 2;
    endfunction

    function automatic logic [7:0] model(
        input logic [15:0] fa, input logic [15:0] fb, input logic [15:0] fr,
        input logic [1:0] fop, input logic fw, input logic [7:0] fcc, input logic [3:0] fen);
        logic at, bt, rt, zz, nn, vv, cc;
        logic [7:0] res;
        int top;
        top = fw ? 15 : 7;
        at = fa[top]; bt = fb[top]; rt = fr[top];
        zz = fw ? (fr == 16'h0) : (fr[7:0] == 8'h0);
        nn = rt;
        cc = fcc[0];
        vv = 1'b0;
        case (fop)
            2'd0: begin cc = maj3(at, bt, !rt);  vv = (at == bt) && (rt != at); end
            2'd1: begin cc = maj3(!at, bt, rt);  vv = (at != bt) && (rt != at); end
            2'd2: begin vv = nn ^ fcc[0]; end
            default: vv = 1'b0;
        endcase
        res = fcc;
        if (fen[3]) res[3] = nn;
        if (fen[2]) res[2] = zz;
        if (fen[1]) res[1] = vv;
        if (fen[0]) res[0] = cc;
        return res;
    endfunction

    task automatic apply(input logic [15:0] ta, input logic [15:0] tb, input logic [15:0] tr,
                         input logic [1:0] top, input logic tw, input logic [7:0] tcc,
                         input logic [3:0] ten, input string req);
        logic [7:0] exp;
        @(negedge clk);
        a = ta; b = tb; r = tr; op = top; wide = tw; ccr_in = tcc; en = ten;
        #2;
        exp = model(ta, tb, tr, top, tw, tcc, ten);
        n_vec++;
        if (ccr_out !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%0d wide=%0d a=%h b=%h r=%h actual=%h expected=%h",
                     req, top, tw, ta, tb, tr, ccr_out, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] o);
        case (o)
            2'd0: return "R1/R2/R7";
            2'd1: return "R3/R4/R7";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        a = '0; b = '0; r = '0; op = '0; wide = 1'b0; ccr_in = 8'h00; en = 4'h0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R9 R10 start-up: nothing enabled, byte passes untouched
        apply(16'h1234, 16'h4321, 16'h0000, 2'd0, 1'b1, 8'hA5, 4'h0, "R9");
        // R1 R2 R7 directed: 0x7F+1 -> 0x80, V=1 C=0 N=1
        apply(16'h007F, 16'h0001, 16'h0080, 2'd0, 1'b0, 8'h00, 4'hF, "R2");
        // R1: 0xFF+1 -> 0x00, C=1 Z=1
        apply(16'h00FF, 16'h0001, 16'h0000, 2'd0, 1'b0, 8'h00, 4'hF, "R1");
        // R8: upper byte noise in narrow mode ignored for Z
        apply(16'hAAFF, 16'h5501, 16'hFF00, 2'd0, 1'b0, 8'h00, 4'hF, "R8");
        // R4: 16-bit 0x8000-1 -> 0x7FFF, V=1 C=0
        apply(16'h8000, 16'h0001, 16'h7FFF, 2'd1, 1'b1, 8'h00, 4'hF, "R4");
        // R3: 16-bit 0-1 -> 0xFFFF, C=1 N=1
        apply(16'h0000, 16'h0001, 16'hFFFF, 2'd1, 1'b1, 8'h00, 4'hF, "R3");
        // R8: same 8-bit values in wide mode take bit 15
        apply(16'h0080, 16'h0001, 16'h007F, 2'd1, 1'b1, 8'h00, 4'hF, "R8");
        // R5: shift with C already set, r top set -> V=0
        apply(16'h0000, 16'h0000, 16'h0080, 2'd2, 1'b0, 8'h01, 4'hF, "R5");
        // R5: shift result zero with C set -> Z=1 V=1
        apply(16'h0000, 16'h0000, 16'h0000, 2'd2, 1'b1, 8'h01, 4'hF, "R5");
        // R6: test clears V and keeps C
        apply(16'h0000, 16'h0000, 16'h8000, 2'd3, 1'b1, 8'h03, 4'hF, "R6");
        // R10: upper bits kept with all enables
        apply(16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 8'hF0, 4'hF, "R10");
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] rop;
            rop = 2'($urandom_range(0, 3));
            apply(16'($urandom), 16'($urandom), 16'($urandom), rop,
                  1'($urandom), 8'($urandom), 4'($urandom), req_of(rop));
        end
        // R9: random enables with sparse results for the zero flag
        for (int i = 0; i < 400; i++) begin
            logic w;
            w = 1'($urandom);
            apply(16'($urandom), 16'($urandom), w ? 16'h0000 : {8'($urandom), 8'h00},
                  2'($urandom_range(0, 3)), w, 8'($urandom), 4'($urandom), "R9");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule